// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial bit stream. Bytes go into a small first-in first-out buffer. A framing engine takes them out one at a time and sends each one as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval. The stop interval can be set in sixteenths of a bit. All bit timing comes from an external tick that pulses sixteen times per bit period. When no character is queued, the line stays high.

Three one-cycle commands control the block. Enable allows host writes and transmission. Disable stops new characters from starting but lets the character already on the line finish. Reset drops everything at once. Two status outputs tell the host about the buffer. The ready flag means there is room for at least one more byte. The empty flag means the buffer is drained and the last stop interval has ended.

Top module: `sertx_top`

## Requirements
- R1: While `rst_n` is low and after reset, `txd` is 1, and `tx_rdy` and `tx_emt` are both 0 (the transmitter starts disabled).
- R2: A character starts with `txd` low for 16 ticks. Then come the data bits, least significant bit first, each held for 16 ticks. The number of data bits is 5 + `cfg_len`, so codes 0..3 give 5..8 bits, and the upper bits of the written byte are ignored.
- R3: When `cfg_par_en` is 1, one parity bit of 16 ticks follows the data. With `cfg_par_odd` = 0, the data bits plus the parity bit hold an even number of ones. With `cfg_par_odd` = 1, they hold an odd number of ones.
- R4: The stop interval is high and lasts 9 + `cfg_stop` ticks for codes 0..7, and 17 + `cfg_stop` ticks for codes 8..15. This gives 9/16 up to 1 bit, then 25/16 up to 2 bits.
- R5: `tx_rdy` is 1 exactly when the transmitter is enabled and the buffer holds fewer than DEPTH (16) bytes.
- R6: `tx_emt` is 1 exactly when the transmitter is enabled, the buffer is empty and no character is on the line. Whenever `tx_emt` is 1, `tx_rdy` is also 1.
- R7: A write is ignored when the transmitter is disabled, and it is dropped when the buffer already holds DEPTH bytes.
- R8: The commands take effect on the clock edge where they are sampled, with priority reset over disable over enable. Disable lets the current character finish. Bytes still queued stay in the buffer and are sent after the next enable.
- R9: `cmd_reset` stops the current character at once: `txd` is 1 from the next cycle, and the buffer is emptied.
- R10: The mode inputs are captured when a character is taken from the buffer. The next queued character is taken one clock after the previous stop interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick16 | input | 1 | One-cycle pulse, sixteen per bit period |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| cmd_enable | input | 1 | Enable the transmitter |
| cmd_disable | input | 1 | Disable after the current character |
| cmd_reset | input | 1 | Abort, flush and disable |
| cfg_len | input | 2 | Data length code, 5 + code bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop | input | 4 | Stop length code |
| txd | output | 1 | Serial output, idles high |
| tx_rdy | output | 1 | Room in the buffer |
| tx_emt | output | 1 | Buffer empty and line idle |

## Verification
A corrupted buffer count shows up first on `tx_rdy` or `tx_emt`, in the same cycle the count goes wrong. It also shows up later on `txd` as a missing or repeated character. A wrong tick counter or wrong bit index moves a `txd` edge by at least one clock within the character that holds the error. A wrong shift register or parity value flips a `txd` level at that bit. A reference model steps alongside the design and compares all three outputs on every clock, so any such fault is caught in the first cycle it reaches a port.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam int unsigned TICKS_PER_BIT = 16;
   localparam int unsigned MAX_BITS      = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } phase_e;

   typedef struct packed {
      logic [1:0] len_code;
      logic       par_en;
      logic       par_odd;
      logic [3:0] stop_code;
   } mode_t;

   // Stop length in ticks: codes 0..7 give 9..16 ticks, codes 8..15 give 25..32 ticks.
   function automatic logic [5:0] stop_ticks(input logic [3:0] code);
      return code[3] ? 6'(17 + code) : 6'(9 + code);
   endfunction

   // Number of data bits: 5 + code.
   function automatic logic [3:0] data_bits(input logic [1:0] code);
      return 4'(5 + code);
   endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic [$clog2(DEPTH):0]     count
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("sertx_fifo: DEPTH must be at least 2");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("sertx_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rd_ptr];
   assign count = cnt_q;

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> (cnt_q != CW'(DEPTH)));
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> (cnt_q != '0));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        abort,
   input  logic        tick,
   input  logic        go,
   input  logic [7:0]  head,
   input  mode_t       mode,
   output logic        txd,
   output logic        busy
);
   localparam int unsigned CNTW = 6;
   localparam logic [CNTW-1:0] BIT_LAST = CNTW'(TICKS_PER_BIT - 1);

   phase_e          phase;
   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] stop_last;
   logic [2:0]      bit_i;
   logic [2:0]      bit_last;
   logic [7:0]      sh;
   logic            par_bit;
   logic            par_on;
   logic            txd_q;

   logic [CNTW-1:0] lim;
   logic [7:0]      mask;
   logic [7:0]      masked;
   logic [3:0]      nbits;

   always_comb begin
      nbits  = data_bits(mode.len_code);
      mask   = 8'((9'd1 << nbits) - 9'd1);
      masked = head & mask;
      lim    = (phase == PH_STOP) ? stop_last : BIT_LAST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         stop_last <= '0;
         bit_i     <= '0;
         bit_last  <= '0;
         sh        <= '0;
         par_bit   <= 1'b0;
         par_on    <= 1'b0;
         txd_q     <= 1'b1;
      end else if (abort) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         txd_q <= 1'b1;
      end else if (phase == PH_IDLE) begin
         txd_q <= 1'b1;
         if (go) begin
            phase     <= PH_START;
            txd_q     <= 1'b0;
            cnt       <= '0;
            sh        <= masked;
            bit_i     <= '0;
            bit_last  <= 3'(nbits - 4'd1);
            par_on    <= mode.par_en;
            par_bit   <= (^masked) ^ mode.par_odd;
            stop_last <= CNTW'(stop_ticks(mode.stop_code) - 6'd1);
         end
      end else if (tick) begin
         if (cnt != lim) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
            unique case (phase)
               PH_START: begin
                  phase <= PH_DATA;
                  txd_q <= sh[0];
               end
               PH_DATA: begin
                  if (bit_i == bit_last) begin
                     phase <= par_on ? PH_PARITY : PH_STOP;
                     txd_q <= par_on ? par_bit : 1'b1;
                  end else begin
                     bit_i <= bit_i + 1'b1;
                     sh    <= sh >> 1;
                     txd_q <= sh[1];
                  end
               end
               PH_PARITY: begin
                  phase <= PH_STOP;
                  txd_q <= 1'b1;
               end
               PH_STOP: begin
                  phase <= PH_IDLE;
                  txd_q <= 1'b1;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign txd  = txd_q;
   assign busy = (phase != PH_IDLE);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd_q);
   assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STOP) |-> txd_q);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd_q);
   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (txd_q && !busy));
   assert_go_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !abort && !busy) |=> (busy && !txd_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick16,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       cmd_enable,
   input  logic       cmd_disable,
   input  logic       cmd_reset,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic [3:0] cfg_stop,
   output logic       txd,
   output logic       tx_rdy,
   output logic       tx_emt
);
   localparam int unsigned CW = $clog2(DEPTH) + 1;

   if (DEPTH > 1024) begin : g_bad_depth
      $error("sertx_top: DEPTH above 1024 is not supported");
   end

   logic          enabled_q;
   logic [CW-1:0] fifo_cnt;
   logic [7:0]    head;
   logic          fifo_full, fifo_empty;
   logic          push, pop, busy;
   mode_t         mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           enabled_q <= 1'b0;
      else if (cmd_reset)   enabled_q <= 1'b0;
      else if (cmd_disable) enabled_q <= 1'b0;
      else if (cmd_enable)  enabled_q <= 1'b1;
   end

   always_comb begin
      mode       = '{len_code: cfg_len, par_en: cfg_par_en,
                     par_odd: cfg_par_odd, stop_code: cfg_stop};
      fifo_full  = (fifo_cnt == CW'(DEPTH));
      fifo_empty = (fifo_cnt == '0);
      push       = wr_en && enabled_q && !fifo_full && !cmd_reset;
      pop        = enabled_q && !fifo_empty && !busy && !cmd_reset;
   end

   sertx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (cmd_reset),
      .push  (push),
      .din   (wr_data),
      .pop   (pop),
      .dout  (head),
      .count (fifo_cnt)
   );

   sertx_framer u_framer (
      .clk   (clk),
      .rst_n (rst_n),
      .abort (cmd_reset),
      .tick  (baud_tick16),
      .go    (pop),
      .head  (head),
      .mode  (mode),
      .txd   (txd),
      .busy  (busy)
   );

   assign tx_rdy = enabled_q && !fifo_full;
   assign tx_emt = enabled_q && fifo_empty && !busy;

   assert_emt_implies_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_emt |-> tx_rdy);
   assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled_q && !cmd_reset) |=> (fifo_cnt == $past(fifo_cnt)));
   assert_reset_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (fifo_cnt == '0 && !tx_rdy && !tx_emt));
   assert_disable_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_disable || cmd_reset) |=> !tx_rdy);

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic [3:0] cfg_stop = 4'd7;
   logic       txd, tx_rdy, tx_emt;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int tick_div = 1;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sertx_top dut (
      .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16),
      .wr_en(wr_en), .wr_data(wr_data),
      .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop(cfg_stop), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
   );

   // ---------------- reference model (behavioural) ----------------
   byte unsigned q[$];
   bit  m_en;
   int  m_ph;      // 0 idle, 1 start, 2 data, 3 parity, 4 stop
   int  m_cnt, m_bit, m_nb, m_stop;
   int  m_sh;
   bit  m_par, m_pen, m_txd;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         q.delete(); m_en = 0; m_ph = 0; m_cnt = 0; m_txd = 1;
      end else begin
         bit start, acc;
         start = m_en && q.size() > 0 && m_ph == 0 && !cmd_reset;
         acc   = wr_en && m_en && q.size() < 16 && !cmd_reset;
         if (cmd_reset) begin
            m_ph = 0; m_cnt = 0; m_txd = 1;
         end else if (m_ph == 0) begin
            m_txd = 1;
            if (start) begin
               int ones;
               m_nb  = 5 + cfg_len;
               m_sh  = q[0] & ((1 << m_nb) - 1);
               ones  = 0;
               for (int i = 0; i < 8; i++) ones += (m_sh >> i) & 1;
               m_par = (ones % 2 == 1) ^ cfg_par_odd;
               m_pen = cfg_par_en;
               m_stop = (cfg_stop < 8) ? 9 + cfg_stop : 17 + cfg_stop;
               m_ph = 1; m_cnt = 0; m_bit = 0; m_txd = 0;
            end
         end else if (baud_tick16) begin
            int last;
            last = (m_ph == 4) ? m_stop - 1 : 15;
            if (m_cnt != last) m_cnt++;
            else begin
               m_cnt = 0;
               case (m_ph)
                  1: begin m_ph = 2; m_bit = 0; m_txd = m_sh & 1; end
                  2: begin
                     if (m_bit == m_nb - 1) begin
                        m_ph  = m_pen ? 3 : 4;
                        m_txd = m_pen ? m_par : 1'b1;
                     end else begin
                        m_bit++;
                        m_txd = (m_sh >> m_bit) & 1;
                     end
                  end
                  3: begin m_ph = 4; m_txd = 1; end
                  default: begin m_ph = 0; m_txd = 1; end
               endcase
            end
         end
         if (cmd_reset) q.delete();
         else begin
            if (start) void'(q.pop_front());
            if (acc) q.push_back(wr_data);
         end
         if (cmd_reset) m_en = 0;
         else if (cmd_disable) m_en = 0;
         else if (cmd_enable) m_en = 1;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_rdy, e_emt;
         e_rdy = m_en && q.size() < 16;
         e_emt = m_en && q.size() == 0 && m_ph == 0;
         checks += 3;
         if (txd !== m_txd) begin
            errors++;
            $display("FAIL R2,R3,R4,R10 txd at cycle %0d: actual %0b expected %0b", cyc, txd, m_txd);
         end
         if (tx_rdy !== e_rdy) begin
            errors++;
            $display("FAIL R5 tx_rdy at cycle %0d: actual %0b expected %0b", cyc, tx_rdy, e_rdy);
         end
         if (tx_emt !== e_emt) begin
            errors++;
            $display("FAIL R6 tx_emt at cycle %0d: actual %0b expected %0b", cyc, tx_emt, e_emt);
         end
      end
   end

   // tick generator
   always @(negedge clk) begin
      baud_tick16 <= (tick_div > 0) && (cyc % tick_div == 0);
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected under 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse(input bit en, input bit dis, input bit rst);
      @(negedge clk); cmd_enable = en; cmd_disable = dis; cmd_reset = rst;
      @(negedge clk); cmd_enable = 1'b0; cmd_disable = 1'b0; cmd_reset = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (tx_emt) break;
      end
      chk(tx_emt === 1'b1, "R6 drain to empty", tx_emt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during and after reset
      chk(txd === 1'b1 && tx_rdy === 1'b0 && tx_emt === 1'b0, "R1 reset state",
          {txd, tx_rdy, tx_emt}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1 && tx_rdy === 1'b0 && tx_emt === 1'b0, "R1 after reset",
          {txd, tx_rdy, tx_emt}, 3'b100);

      // R7: writes while disabled are ignored
      wr(8'h11); wr(8'h22);
      pulse(1, 0, 0);
      chk(tx_rdy === 1'b1 && tx_emt === 1'b1, "R7 disabled writes ignored",
          {tx_rdy, tx_emt}, 2'b11);
      repeat (40) @(negedge clk);
      chk(txd === 1'b1, "R7 no char from disabled write", txd, 1);

      // R2: 8 data bits, no parity, stop 16 ticks, tick every cycle
      tick_div = 1; cfg_len = 2'd3; cfg_par_en = 0; cfg_stop = 4'd7;
      wr(8'hA5); wr(8'h3C);
      wait_idle();

      // R3 even parity, 5 bits, R4 minimum stop 9/16, ticks every 3 cycles
      tick_div = 3; cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop = 4'd0;
      wr(8'hFF); wr(8'h13); wr(8'h00);
      wait_idle();

      // R3 odd parity, 7 bits, R4 longest stop; R10 mode change mid-character
      tick_div = 2; cfg_len = 2'd2; cfg_par_odd = 1; cfg_stop = 4'd15;
      wr(8'h5A); wr(8'hC3);
      repeat (30) @(negedge clk);
      cfg_len = 2'd1; cfg_stop = 4'd8; cfg_par_en = 0;
      wait_idle();

      // R5/R7: fill with ticks stopped, overflow dropped
      tick_div = 0; cfg_len = 2'd3; cfg_stop = 4'd3;
      for (int i = 0; i < 18; i++) wr(8'(i * 7 + 1));
      chk(tx_rdy === 1'b0, "R5 full clears ready", tx_rdy, 0);
      tick_div = 1;
      wait_idle();

      // R8: disable mid-character lets it finish, queue held
      wr(8'h81); wr(8'h42); wr(8'h24);
      repeat (50) @(negedge clk);
      pulse(0, 1, 0);
      chk(tx_rdy === 1'b0 && tx_emt === 1'b0, "R8 disable clears status",
          {tx_rdy, tx_emt}, 0);
      repeat (400) @(negedge clk);
      chk(txd === 1'b1, "R8 idle after finishing", txd, 1);
      pulse(1, 0, 0);
      chk(tx_rdy === 1'b1 && tx_emt === 1'b0, "R8 queued bytes resume",
          {tx_rdy, tx_emt}, 2'b10);
      wait_idle();

      // R8 priority: disable over enable, reset over enable
      pulse(0, 1, 0);
      pulse(1, 1, 0);
      chk(tx_rdy === 1'b0, "R8 disable beats enable", tx_rdy, 0);
      pulse(1, 0, 1);
      chk(tx_rdy === 1'b0, "R8 reset beats enable", tx_rdy, 0);

      // R9: reset aborts mid-character and flushes
      pulse(1, 0, 0);
      wr(8'h00); wr(8'h00); wr(8'h00);
      repeat (20) @(negedge clk);
      chk(txd === 1'b0, "R9 line low before abort", txd, 0);
      pulse(0, 0, 1);
      chk(txd === 1'b1 && tx_rdy === 1'b0 && tx_emt === 1'b0, "R9 abort state",
          {txd, tx_rdy, tx_emt}, 3'b100);
      pulse(1, 0, 0);
      chk(tx_emt === 1'b1, "R9 buffer flushed", tx_emt, 1);
      repeat (60) @(negedge clk);
      chk(txd === 1'b1, "R9 nothing sent after flush", txd, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule